// File: doc/BRIEF.md
# Bit-Error Injector for a Test-Pattern Transmit Stream

The block sits between a serial test-pattern generator and the line. It takes one pattern bit per clock with a valid strobe. It returns the bit one clock later, inverted when an error is due. There are two ways to cause an error. A decimal rate code k makes the block invert one bit in every 10^k valid bits. A rising edge on a one-shot control inverts the next valid bit once. A master enable gates both sources.

A new rate code is not applied at once while an interval is running. The block keeps counting at the old rate until that interval ends with an inserted error, and only then takes the new code. Several one-shot edges that arrive before a valid bit can take them produce a single error. A one-cycle marker comes out with each inverted bit.

Top module: `bert_err_inject`

## Requirements
- R1: With rate code k in 1..7 and rate-based insertion running, the block inverts the valid bit that ends each run of 10^k valid bits, counted from the point the code was taken up. Code 0 turns rate-based insertion off.
- R2: With rate code 1, every 10th valid bit is inverted, and no other bit.
- R3: While `inj_en_i` is 0, no bit is inverted and `err_ins_o` stays 0, even when a rate code is set or one-shot edges arrive.
- R4: A 0-to-1 transition of `one_shot_i`, seen while enabled, inverts exactly one bit: the first valid bit presented in a later cycle.
- R5: Any number of `one_shot_i` rising edges before the next valid bit add up to one error only.
- R6: If the rate code changes while an interval is running, the old rate stays in force until the next rate-based error, and the new rate counts from that error. This includes a change to code 0.
- R7: Only cycles with `pat_vld_i` = 1 advance the rate interval. Cycles with `pat_vld_i` = 0 produce `pat_vld_o` = 0 one cycle later and never carry an error.
- R8: If a one-shot error and a rate-based error fall on the same bit, that bit is inverted once, with a single `err_ins_o` pulse.
- R9: `err_ins_o` is 1 for exactly the output cycle whose `pat_bit_o` differs from the input bit it came from. That cycle always has `pat_vld_o` = 1.
- R10: Setting `inj_en_i` to 0 for one cycle drops a pending one-shot request and restarts the rate interval. After re-enabling, the first rate error falls on the 10^k-th valid bit.
- R11: Each output is registered and appears one clock after its input. All outputs are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| pat_bit_i | input | 1 | Pattern bit from the generator |
| pat_vld_i | input | 1 | Qualifies `pat_bit_i` |
| inj_en_i | input | 1 | Master enable for all insertion |
| rate_code_i | input | CODE_W (3) | Decimal rate exponent k, 0 = off |
| one_shot_i | input | 1 | Single-error request, acts on its rising edge |
| pat_bit_o | output | 1 | Bit out, inverted when an error is inserted |
| pat_vld_o | output | 1 | Valid for `pat_bit_o` |
| err_ins_o | output | 1 | One-cycle marker of an inverted bit |

## Verification
The block's only internal state is the interval counter, the code in force and the one-shot pending flag. Any of them going wrong shows up as an inverted bit in the wrong position, counted in valid bits. A miscount of the counter or a premature code switch moves the next error by at least one bit. This is seen within one interval: 10 bits at code 1, 1000 at code 3. A stuck or doubled pending flag changes the error count at the first valid bit after a one-shot edge. A scoreboard that holds the expected flip position for every bit catches each of these at the first wrong output.

// File: rtl/bei_pkg.sv
package bei_pkg;

   // Largest exponent the period table is built for.
   localparam int unsigned BEI_MAX_EXP = 9;

   // Compute 10^k at elaboration time. The loop bound is fixed.
   function automatic int unsigned bei_pow10(input int unsigned k);
      int unsigned r;
      r = 1;
      for (int unsigned i = 0; i < BEI_MAX_EXP; i++) begin
         if (i < k) r = r * 10;
      end
      return r;
   endfunction

   typedef struct packed {
      logic data;
      logic vld;
      logic err;
   } bei_beat_t;

endpackage

// File: rtl/bei_rate_ctr.sv
module bei_rate_ctr
   import bei_pkg::*;
#(
   parameter int CODE_W = 3,
   parameter int CNT_W  = 24
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              en_i,
   input  logic              vld_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              hit_o
);
   localparam int NCODE = 1 << CODE_W;

   initial begin
      assert (NCODE - 1 <= int'(BEI_MAX_EXP))
         else $error("CODE_W too wide for the decimal period table");
      assert (64'(bei_pow10(NCODE - 1)) <= (64'(1) << CNT_W))
         else $error("CNT_W too narrow for the longest interval");
   end

   // Terminal count for each code, 10^k - 1. Entry 0 is never used.
   logic [CNT_W-1:0] term_tab [NCODE];
   for (genvar g = 0; g < NCODE; g++) begin : g_tab
      assign term_tab[g] = CNT_W'(bei_pow10(g) - 1);
   end

   logic [CNT_W-1:0]  cnt_q;
   logic [CODE_W-1:0] act_q;
   logic              at_term;

   assign at_term = (cnt_q == term_tab[act_q]);
   assign hit_o   = en_i & vld_i & (act_q != '0) & at_term;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         act_q <= '0;
      end else if (!en_i) begin
         cnt_q <= '0;
         act_q <= '0;
      end else if (act_q == '0) begin
         act_q <= code_i;
         cnt_q <= '0;
      end else if (vld_i) begin
         if (at_term) begin
            cnt_q <= '0;
            act_q <= code_i;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act_q != '0) |-> (cnt_q <= term_tab[act_q])); // R1

   AST_CODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((act_q != $past(act_q)) && ($past(act_q) != '0) && $past(en_i)) |-> $past(hit_o)); // R6

   AST_INVALID_NO_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !vld_i && act_q != '0) |=> $stable(cnt_q)); // R7

endmodule

// File: rtl/bei_single_arm.sv
module bei_single_arm (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   input  logic vld_i,
   input  logic req_i,
   output logic take_o
);
   logic req_q;
   logic pend_q;
   logic rise;

   assign rise   = req_i & ~req_q;
   assign take_o = en_i & vld_i & pend_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         req_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         req_q  <= req_i;
         pend_q <= en_i & (rise | (pend_q & ~vld_i));
      end
   end

   AST_SINGLE_CONSUMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take_o && !rise) |=> !pend_q); // R5

   AST_DISABLE_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> !pend_q); // R10

endmodule

// File: rtl/bert_err_inject.sv
module bert_err_inject
   import bei_pkg::*;
#(
   parameter int CODE_W  = 3,
   parameter int CNT_W   = 24,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              pat_bit_i,
   input  logic              pat_vld_i,
   input  logic              inj_en_i,
   input  logic [CODE_W-1:0] rate_code_i,
   input  logic              one_shot_i,
   output logic              pat_bit_o,
   output logic              pat_vld_o,
   output logic              err_ins_o
);
   logic      rate_hit;
   logic      shot_take;
   bei_beat_t beat_d;

   bei_rate_ctr #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_rate (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (inj_en_i),
      .vld_i  (pat_vld_i),
      .code_i (rate_code_i),
      .hit_o  (rate_hit)
   );

   bei_single_arm u_shot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (inj_en_i),
      .vld_i  (pat_vld_i),
      .req_i  (one_shot_i),
      .take_o (shot_take)
   );

   // Both sources share one inversion, so a coincident pair flips the bit once.
   always_comb begin
      beat_d.err  = rate_hit | shot_take;
      beat_d.data = pat_bit_i ^ beat_d.err;
      beat_d.vld  = pat_vld_i;
   end

   if (OUT_REG) begin : g_reg
      bei_beat_t beat_q;
      always_ff @(posedge clk_i) begin
         if (!rst_ni) beat_q <= '0;
         else         beat_q <= beat_d;
      end
      assign pat_bit_o = beat_q.data;
      assign pat_vld_o = beat_q.vld;
      assign err_ins_o = beat_q.err;

      AST_OFF_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !inj_en_i |=> !err_ins_o); // R3

      AST_FLIP_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
         pat_vld_o |-> ((pat_bit_o ^ $past(pat_bit_i)) == err_ins_o)); // R9

      AST_VLD_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
         pat_vld_i |=> pat_vld_o); // R11
   end else begin : g_comb
      assign pat_bit_o = beat_d.data;
      assign pat_vld_o = beat_d.vld;
      assign err_ins_o = beat_d.err;
   end

   AST_ERR_ON_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_ins_o |-> pat_vld_o); // R9

endmodule

// File: tb/bert_err_inject_bench.sv
`timescale 1ns/1ps
module bert_err_inject_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_i = 1'b0, vld_i = 1'b0, en_i = 1'b0, shot_i = 1'b0;
   logic [2:0] code_i = 3'd0;
   logic       bit_o, vld_o, err_o;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   typedef struct {
      logic  b;
      logic  e;
      string tag;
   } exp_t;
   exp_t sb[$];

   always #10ns clk = ~clk;

   bert_err_inject u_bert_err_inject (
      .clk_i(clk), .rst_ni(rst_n), .pat_bit_i(bit_i), .pat_vld_i(vld_i),
      .inj_en_i(en_i), .rate_code_i(code_i), .one_shot_i(shot_i),
      .pat_bit_o(bit_o), .pat_vld_o(vld_o), .err_ins_o(err_o)
   );

   task automatic fail_line(string tag, string what, int act, int exp);
      n_fail++;
      $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // Monitor: compares each output beat against the head of the scoreboard.
   always @(negedge clk) begin
      if (rst_n && vld_o) begin
         n_chk++;
         if (sb.size() == 0) begin
            fail_line("R11", "unexpected output beat", 1, 0);
         end else begin
            exp_t x;
            x = sb.pop_front();
            if (bit_o !== x.b || err_o !== x.e)
               fail_line(x.tag, "bit/err", {30'd0, bit_o, err_o}, {30'd0, x.b, x.e});
         end
      end
   end

   // One idle cycle with optional one-shot level.
   task automatic idle(logic shot);
      @(negedge clk);
      vld_i  = 1'b0;
      bit_i  = 1'($urandom);
      shot_i = shot;
   endtask

   task automatic pulse_shot();
      idle(1'b1);
      idle(1'b0);
   endtask

   // Send n valid bits; flips expected at index 'first' and then every 'per'
   // (per=0: only at 'first'; first<0: none). Idle gaps are mixed in (R7).
   task automatic send_run(int n, int first, int per, string tag);
      for (int i = 0; i < n; i++) begin
         logic f;
         exp_t x;
         if (i % 7 == 3) idle(1'b0);
         f = (first >= 0) && (i >= first) &&
             ((per == 0) ? (i == first) : ((i - first) % per == 0));
         @(negedge clk);
         vld_i  = 1'b1;
         bit_i  = 1'($urandom);
         shot_i = 1'b0;
         x.b = bit_i ^ f;
         x.e = f;
         x.tag = tag;
         sb.push_back(x);
      end
      idle(1'b0);
   endtask

   initial begin
      #(20ns * 150000);
      if (!done) begin
         n_chk++;
         fail_line("R11", "watchdog expired", 0, 1);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      n_chk++;
      if ({bit_o, vld_o, err_o} !== 3'b000) fail_line("R11", "reset outputs", {bit_o, vld_o, err_o}, 0);
      rst_n = 1'b1;
      idle(1'b0);

      // R3: disabled, code set, one-shot edge -> no errors
      code_i = 3'd1;
      pulse_shot();
      send_run(25, -1, 0, "R3");

      // R1/R2/R7: code 1, every 10th valid bit
      en_i = 1'b1;
      idle(1'b0);
      send_run(30, 9, 10, "R2");

      // R6: change to code 2 mid-interval; old rate until next error
      send_run(5, -1, 0, "R6");
      code_i = 3'd2;
      send_run(105, 4, 100, "R6");

      // R6/R1: code 0 takes effect after the next error, then nothing
      code_i = 3'd0;
      send_run(100, 99, 0, "R6");
      send_run(50, -1, 0, "R1");

      // R4: single edge inverts the next valid bit only
      pulse_shot();
      send_run(6, 0, 0, "R4");

      // R5: several edges before a valid bit give one error
      pulse_shot();
      pulse_shot();
      pulse_shot();
      send_run(5, 0, 0, "R5");

      // R8: one-shot and rate error on the same bit
      code_i = 3'd1;
      idle(1'b0);
      send_run(9, -1, 0, "R8");
      pulse_shot();
      send_run(11, 0, 10, "R8");

      // R10: disable drops pending request and restarts the interval
      send_run(5, -1, 0, "R10");
      pulse_shot();
      en_i = 1'b0;
      idle(1'b0);
      en_i = 1'b1;
      idle(1'b0);
      send_run(10, 9, 0, "R10");

      // R1: code 3, one error per 1000 bits
      en_i = 1'b0;
      code_i = 3'd3;
      idle(1'b0);
      en_i = 1'b1;
      idle(1'b0);
      send_run(2000, 999, 1000, "R1");

      idle(1'b0);
      idle(1'b0);
      // R11: every expected beat was produced
      n_chk++;
      if (sb.size() != 0) fail_line("R11", "beats left unproduced", sb.size(), 0);
      done = 1'b1;
      finish_run();
   end
endmodule